// File: doc/BRIEF.md
# Queued Hardware Lock Arbiter

This block sits beside the memory path and handles acquire and release operations aimed at a small set of lock addresses. Those addresses are kept out of the private caches. Processors do not spin on a held lock. An acquire that finds its lock busy is held back: the arbiter stores it and gives no answer. When the holder releases the lock, the arbiter answers the oldest waiting acquire, and that processor now owns the lock. The result is a fair queue lock built from ordinary memory operations, and software does not have to change.

Each lock has a waiting line with one slot per processor. A processor keeps at most one acquire outstanding, and it sends nothing while that acquire waits. Each lock also has a watchdog timer. It runs while processors are waiting and restarts whenever ownership changes. If it expires, the oldest waiter gets a fail answer, so that software can retry or fall back to spinning. A request carries a processor id, a lock id and an operation bit. Answers come back one cycle after the request, on a per-processor valid line with a two-bit status.

Top module: `qlock_arbiter`

## Requirements
- R1: An acquire (`req_op`=0) to a free lock sets `rsp_valid` for the requester in the next cycle with status OK, and the requester becomes the holder. Status codes are 2'b00 OK, 2'b01 FAIL and 2'b10 ERR; 2'b11 is never produced.
- R2: An acquire to a lock held by another processor is queued, and the requester gets no response while it waits.
- R3: A release (`req_op`=1) by the holder while processors wait answers both the releaser and the oldest waiter with OK in the same cycle, and that waiter becomes the holder.
- R4: A release by the holder with no waiters answers OK and frees the lock, so that the next acquire from any processor succeeds at once.
- R5: Waiters on a lock are granted in the order their acquires arrived.
- R6: Locks are independent: a request to one lock never changes the state or responses of another.
- R7: A release by a processor that does not hold the lock, including a release of a free lock, answers ERR and leaves the holder and the queue unchanged.
- R8: If TIMEOUT cycles pass with waiters present and no owner change or earlier expiry, the oldest waiter is answered FAIL and removed. The holder is unchanged. The FAIL appears TIMEOUT cycles after the response cycle of the event that started the wait: an enqueue to an empty line, an owner change or an expiry.
- R9: The timeout count restarts at every owner change and after every expiry. A holder's release in the same cycle as an expiry wins: the oldest waiter is granted OK and no FAIL is sent.
- R10: An acquire by the current holder of that lock answers ERR and changes nothing.
- R11: After reset every lock is free, every queue is empty and no response is valid.
- R12: When an expiry and a new acquire to the same held lock fall in the same cycle, the expiry removes the oldest waiter first and the new request joins the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 1 | 0 = acquire, 1 = release |
| req_proc | input | $clog2(NPROC) | Requesting processor id |
| req_lock | input | $clog2(NLOCK) | Target lock id |
| rsp_valid | output | NPROC | Per-processor response strobe |
| rsp_status | output | 2*NPROC | Per-processor status, processor p in bits [2p+1:2p] |

## Verification
Several patterns are applied. An uncontended acquire and release tells the immediate-grant path apart from the queued path. A lock loaded with three waiters and then released twice shows whether hand-over follows arrival order, and whether the waiters stay silent until their turn. Some timing cases are placed on exact cycles: an expiry with no release, a release issued in the very cycle of an expiry, and an acquire that arrives during an expiry. These show whether the timer restarts at each owner change, whether a release takes priority over an expiry, and whether a new request lands behind the waiter that was removed. Misuse is tried as well, with an error release from a non-holder, a release of a free lock and a repeat acquire by the holder. A later normal hand-over on the same lock then shows that the state was not disturbed.

// File: rtl/lkarb_pkg.sv
package lkarb_pkg;

    typedef enum logic {
        OP_ACQ = 1'b0,
        OP_REL = 1'b1
    } lk_op_e;

    typedef enum logic [1:0] {
        ST_OK   = 2'b00,
        ST_FAIL = 2'b01,
        ST_ERR  = 2'b10
    } lk_st_e;

    function automatic int unsigned idx_w(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lkarb_fifo.sv
module lkarb_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = lkarb_pkg::idx_w(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [AW:0]   count;

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == (AW+1)'(DEPTH));

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // R2
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> (!push || pop));

    // R5
    fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> !pop);

endmodule

// File: rtl/lkarb_timer.sv
module lkarb_timer #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign expired = run && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (run)   cnt <= cnt + 1'b1;
    end

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(LIMIT));

endmodule

// File: rtl/lkarb_lock.sv
module lkarb_lock
    import lkarb_pkg::*;
#(
    parameter int NPROC   = 4,
    parameter int TIMEOUT = 32,
    localparam int PW     = idx_w(NPROC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel,
    input  lk_op_e             op,
    input  logic [PW-1:0]      proc,
    output logic [NPROC-1:0]   rsp_vld,
    output logic [2*NPROC-1:0] rsp_st
);
    logic          held;
    logic [PW-1:0] holder;
    logic          is_acq, is_rel, rel_ok, push, pop;
    logic          empty, full, expired, timeout_hit, owner_chg;
    logic [PW-1:0] head;

    assign is_acq      = sel && (op == OP_ACQ);
    assign is_rel      = sel && (op == OP_REL);
    assign rel_ok      = is_rel && held && (proc == holder);
    assign push        = is_acq && held && (proc != holder);
    assign timeout_hit = expired && !rel_ok;
    assign pop         = (rel_ok && !empty) || timeout_hit;
    assign owner_chg   = (is_acq && !held) || (rel_ok && !empty);

    lkarb_fifo #(.DEPTH(NPROC), .W(PW)) u_line (
        .clk(clk), .rst(rst), .push(push), .pop(pop), .din(proc),
        .head(head), .empty(empty), .full(full)
    );

    lkarb_timer #(.LIMIT(TIMEOUT)) u_wdog (
        .clk(clk), .rst(rst),
        .clr(owner_chg || timeout_hit || empty),
        .run(!empty), .expired(expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held   <= 1'b0;
            holder <= '0;
        end else if (is_acq && !held) begin
            held   <= 1'b1;
            holder <= proc;
        end else if (rel_ok) begin
            if (empty) held <= 1'b0;
            else       holder <= head;
        end
    end

    always_comb begin
        rsp_vld = '0;
        rsp_st  = '0;
        if (is_acq && (!held || proc == holder)) begin
            rsp_vld[proc]                 = 1'b1;
            rsp_st[2*int'(proc) +: 2]     = held ? ST_ERR : ST_OK;
        end
        if (is_rel) begin
            rsp_vld[proc]                 = 1'b1;
            rsp_st[2*int'(proc) +: 2]     = rel_ok ? ST_OK : ST_ERR;
        end
        if (pop) begin
            rsp_vld[head]                 = 1'b1;
            rsp_st[2*int'(head) +: 2]     = timeout_hit ? ST_FAIL : ST_OK;
        end
    end

    // R1
    free_acq_chk: assert property (@(posedge clk) disable iff (rst)
        (is_acq && !held) |=> (held && holder == $past(proc)));

    // R3
    handover_chk: assert property (@(posedge clk) disable iff (rst)
        (rel_ok && !empty) |=> (held && holder == $past(head)));

    // R4
    free_on_release_chk: assert property (@(posedge clk) disable iff (rst)
        (rel_ok && empty) |=> !held);

    // R7
    bad_release_chk: assert property (@(posedge clk) disable iff (rst)
        (is_rel && !rel_ok) |=> ($stable(held) && $stable(holder)));

endmodule

// File: rtl/qlock_arbiter.sv
module qlock_arbiter
    import lkarb_pkg::*;
#(
    parameter int NPROC   = 4,
    parameter int NLOCK   = 4,
    parameter int TIMEOUT = 32,
    localparam int PW     = idx_w(NPROC),
    localparam int LKW    = idx_w(NLOCK)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_op,
    input  logic [PW-1:0]      req_proc,
    input  logic [LKW-1:0]     req_lock,
    output logic [NPROC-1:0]   rsp_valid,
    output logic [2*NPROC-1:0] rsp_status
);
    logic [NPROC-1:0]   lk_vld [NLOCK];
    logic [2*NPROC-1:0] lk_st  [NLOCK];
    logic [NPROC-1:0]   nxt_vld;
    logic [2*NPROC-1:0] nxt_st;
    lk_op_e             op;

    assign op = lk_op_e'(req_op);

    for (genvar g = 0; g < NLOCK; g++) begin : g_lock
        lkarb_lock #(.NPROC(NPROC), .TIMEOUT(TIMEOUT)) u_lock (
            .clk(clk), .rst(rst),
            .sel(req_valid && req_lock == LKW'(g)),
            .op(op), .proc(req_proc),
            .rsp_vld(lk_vld[g]), .rsp_st(lk_st[g])
        );
    end

    always_comb begin
        nxt_vld = '0;
        nxt_st  = '0;
        for (int l = 0; l < NLOCK; l++) begin
            for (int p = 0; p < NPROC; p++) begin
                if (lk_vld[l][p]) begin
                    nxt_vld[p]       = 1'b1;
                    nxt_st[2*p +: 2] = lk_st[l][2*p +: 2];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= '0;
            rsp_status <= '0;
        end else begin
            rsp_valid  <= nxt_vld;
            rsp_status <= nxt_st;
        end
    end

    for (genvar p = 0; p < NPROC; p++) begin : g_chk
        // R1
        rsp_code_chk: assert property (@(posedge clk) disable iff (rst)
            rsp_valid[p] |-> (rsp_status[2*p +: 2] != 2'b11));
    end

endmodule

// File: tb/qlock_arbiter_test.sv
module qlock_arbiter_test;
    localparam int NP = 4;
    localparam int NL = 4;
    localparam int T  = 32;
    localparam int OK = 0, FAILC = 1, ERR = 2;
    localparam bit ACQ = 1'b0, REL = 1'b1;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           req_valid = 1'b0;
    logic           req_op = 1'b0;
    logic [1:0]     req_proc = '0;
    logic [1:0]     req_lock = '0;
    logic [NP-1:0]  rsp_valid;
    logic [2*NP-1:0] rsp_status;

    qlock_arbiter #(.NPROC(NP), .NLOCK(NL), .TIMEOUT(T)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_proc(req_proc), .req_lock(req_lock),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int    cyc;
        int    proc;
        int    st;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void expect_rsp(int c, int p, int st, string tag);
        exp_t e;
        e.cyc = c; e.proc = p; e.st = st; e.tag = tag;
        sb.push_back(e);
    endfunction

    // monitor: pops scoreboard entries due this cycle and compares
    always @(negedge clk) begin
        if (mon_on) begin
            for (int p = 0; p < NP; p++) begin
                int hit;
                hit = -1;
                foreach (sb[i]) if (sb[i].cyc == cyc && sb[i].proc == p) hit = i;
                if (hit >= 0) begin
                    checks++;
                    if (!rsp_valid[p] || int'(rsp_status[2*p +: 2]) != sb[hit].st) begin
                        errors++;
                        $display("FAIL %s: proc %0d cycle %0d valid=%0b status=%0d expected valid=1 status=%0d",
                                 sb[hit].tag, p, cyc, rsp_valid[p], rsp_status[2*p +: 2], sb[hit].st);
                    end
                    sb.delete(hit);
                end else if (rsp_valid[p]) begin
                    checks++;
                    errors++;
                    $display("FAIL R2: proc %0d cycle %0d unexpected response status=%0d expected none",
                             p, cyc, rsp_status[2*p +: 2]);
                end
            end
        end
    end

    task automatic issue(int p, int l, bit op, int st_self, string tag);
        if (st_self >= 0) expect_rsp(cyc + 1, p, st_self, tag);
        req_valid = 1'b1; req_proc = 2'(p); req_lock = 2'(l); req_op = op;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_to(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic check_quiet(string tag);
        checks++;
        if (rsp_valid != '0) begin
            errors++;
            $display("FAIL %s: rsp_valid=%b expected 0", tag, rsp_valid);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_quiet("R11");
        mon_on = 1'b1;
        @(negedge clk);
        check_quiet("R11");

        // R1: free acquire, R10: holder re-acquire, R7: stray release
        issue(0, 0, ACQ, OK, "R1");
        issue(0, 0, ACQ, ERR, "R10");
        issue(1, 0, REL, ERR, "R7");

        // R2: three waiters, silent
        issue(1, 0, ACQ, -1, "R2");
        issue(2, 0, ACQ, -1, "R2");
        issue(3, 0, ACQ, -1, "R2");
        check_quiet("R2");

        // R6: another lock is unaffected
        issue(0, 1, ACQ, OK, "R6");
        issue(0, 1, REL, OK, "R6");

        // R3 and R5: hand-over in arrival order
        expect_rsp(cyc + 1, 1, OK, "R3");
        issue(0, 0, REL, OK, "R3");
        c = cyc;
        expect_rsp(c + 1, 2, OK, "R5");
        expect_rsp(c + 1 + T, 3, FAILC, "R8");  // R9: restarted at this owner change
        issue(1, 0, REL, OK, "R5");
        wait_to(c + 2 + T);

        // R9: release in the very cycle of an expiry wins
        c = cyc;
        issue(3, 0, ACQ, -1, "R2");
        wait_to(c + T);
        expect_rsp(cyc + 1, 3, OK, "R9");
        issue(2, 0, REL, OK, "R9");
        repeat (T + 4) @(negedge clk);

        // R4: release with no waiters frees the lock
        issue(3, 0, REL, OK, "R4");
        issue(1, 0, ACQ, OK, "R4");
        issue(1, 0, REL, OK, "R4");
        issue(2, 2, REL, ERR, "R7");

        // R8, R12: expiry chain with an acquire landing during an expiry
        issue(0, 3, ACQ, OK, "R1");
        c = cyc;
        expect_rsp(c + 1 + T, 1, FAILC, "R8");
        expect_rsp(c + 1 + 2*T, 2, FAILC, "R12");
        expect_rsp(c + 1 + 3*T, 3, FAILC, "R12");
        issue(1, 3, ACQ, -1, "R2");
        issue(2, 3, ACQ, -1, "R2");
        wait_to(c + T);
        issue(3, 3, ACQ, -1, "R12");
        wait_to(c + 2 + 3*T);
        issue(0, 3, REL, OK, "R4");
        issue(2, 3, ACQ, OK, "R4");
        repeat (3) @(negedge clk);

        foreach (sb[i]) begin
            checks++; errors++;
            $display("FAIL %s: proc %0d response missing at cycle %0d, expected status=%0d",
                     sb[i].tag, sb[i].proc, sb[i].cyc, sb[i].st);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule